// File: doc/BRIEF.md
# Quad PWM with Cascaded Step Prescalers

This block generates four independent pulse-width-modulated outputs from one input clock. Software programs it through a small synchronous register port. A shared control word carries a run bit and a 2-bit step-rate select for every channel. Each channel also has its own configuration word, which holds the period length in steps (the timebase) and the number of steps the output stays high (the duty count).

Every channel owns a prescaler made of two counters. The first divides by 8 and the second by 64. Chaining them gives division by 512. The prescaler issues a one-cycle step enable, and no derived clock is ever formed. The step counter of each channel advances on that enable and compares against the duty count to shape the output.

New timebase and duty values go into live registers. They are copied into working shadow copies only when a period closes, so every period on the pin is whole. Stopping a channel clears its counters and pulls its pin low. Starting it again begins a clean period.

Top module: `pwm_quad`

## Requirements
- R1: After reset, every mapped register reads zero and all four outputs are low.
- R2: The control word at offset 0x00 reads back exactly as written. Bit n (n = 0..3) runs channel n. Bits [2n+5:2n+4] select its step rate: 0 = every cycle, 1 = every 8th cycle, 2 = every 64th cycle, 3 = every 512th cycle.
- R3: The configuration word of channel n sits at offset 0x04 + 4n. Bits [15:0] hold the timebase and bits [31:16] hold the duty count. A timebase above 255 is stored as 255, and bits [15:8] of the word read back as zero.
- R4: While a channel runs, its output is high when its step count is below the duty count and low otherwise. The step count runs 0 to timebase−1 and then wraps. The first cycle after the run bit is set is step 0.
- R5: With step-rate code c, every step lasts 8^c input cycles, so one period lasts timebase·8^c cycles.
- R6: A duty count of 0 keeps the output low. A duty count equal to or greater than the timebase keeps it high.
- R7: A configuration write takes effect only at the next period boundary. A write that lands in the last cycle of a period is applied one period later.
- R8: Clearing a run bit drives that output low from the next cycle. Setting it again restarts both the prescaler and the step count from zero.
- R9: A channel whose timebase is 0 keeps its output low even when its run bit is set.
- R10: Channels run independently. A write to one channel's configuration word leaves the other words unchanged, and channels with different settings produce their own waveforms at the same time.
- R11: A write with address bits [1:0] non-zero, or to a word above offset 0x10, changes no register. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
Two events can fall in the same cycle: a period-closing shadow reload and a bus write to that channel's configuration word. The bench provokes this by stepping channel 0 until its last step and issuing the write in exactly that cycle. It then judges that the next whole period still uses the old timebase and duty, and that the new ones appear only one period later. A second collision is a stop request that lands in the middle of a prescaler count. This one is judged by the output going low at once and by a clean, full first period after the restart.

// File: rtl/pwmq_pkg.sv
`timescale 1ns/1ps
package pwmq_pkg;

   // Step-rate select codes; the numeric values are decoded by the prescaler.
   typedef enum logic [1:0] {
      STEP_EVERY = 2'd0,
      STEP_DIV_A = 2'd1,
      STEP_DIV_B = 2'd2,
      STEP_DIV_AB = 2'd3
   } step_sel_e;

   // Layout of the shared control word: run bits low, select fields above.
   localparam int SEL_BASE = 4;
   localparam int SEL_W    = 2;

endpackage

// File: rtl/pwmq_regs.sv
`timescale 1ns/1ps
module pwmq_regs #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32,
   parameter int TB_W   = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  we,
   input  logic [ADDR_W-1:0]                     addr,
   input  logic [DATA_W-1:0]                     wdata,
   output logic [DATA_W-1:0]                     rdata,
   output logic [NUM_CH-1:0]                     ch_run,
   output logic [NUM_CH-1:0][pwmq_pkg::SEL_W-1:0] ch_sel,
   output logic [NUM_CH-1:0][TB_W-1:0]           ch_tb,
   output logic [NUM_CH-1:0][DATA_W/2-1:0]       ch_duty
);
   import pwmq_pkg::*;

   localparam int FLD_W  = DATA_W / 2;
   localparam int IDX_W  = ADDR_W - 2;
   localparam int TB_MAX = (1 << TB_W) - 1;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (SEL_BASE + SEL_W * NUM_CH > DATA_W || NUM_CH > SEL_BASE) begin : g_bad_ctrl
      $error("control word cannot hold the run bits and select fields");
   end
   if ((1 << IDX_W) < NUM_CH + 1) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end
   if (TB_W >= FLD_W || DATA_W % 2 != 0) begin : g_bad_tb
      $error("TB_W must be narrower than half the data word");
   end

   logic [DATA_W-1:0]           ctrl_q;
   logic [NUM_CH-1:0][TB_W-1:0] tb_q;
   logic [NUM_CH-1:0][FLD_W-1:0] duty_q;
   logic                        aligned;
   logic [IDX_W-1:0]            word_idx;
   logic [TB_W-1:0]             tb_sat;

   assign aligned  = (addr[1:0] == 2'b00);
   assign word_idx = addr[ADDR_W-1:2];
   assign tb_sat   = (wdata[FLD_W-1:0] > FLD_W'(TB_MAX)) ? TB_W'(TB_MAX)
                                                         : wdata[TB_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (we && aligned && word_idx == '0) begin
         ctrl_q <= wdata;
      end
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tb_q[n]   <= '0;
            duty_q[n] <= '0;
         end else if (we && aligned && word_idx == IDX_W'(n + 1)) begin
            tb_q[n]   <= tb_sat;
            duty_q[n] <= wdata[DATA_W-1:FLD_W];
         end
      end
      assign ch_run[n]  = ctrl_q[n];
      assign ch_sel[n]  = ctrl_q[SEL_BASE + SEL_W*n +: SEL_W];
      assign ch_tb[n]   = tb_q[n];
      assign ch_duty[n] = duty_q[n];
   end

   always_comb begin
      rdata = '0;
      if (aligned) begin
         if (word_idx == '0) rdata = ctrl_q;
         for (int n = 0; n < NUM_CH; n++) begin
            if (word_idx == IDX_W'(n + 1)) begin
               rdata = {duty_q[n], (FLD_W - TB_W)'(0), tb_q[n]};
            end
         end
      end
   end

   // R11
   misaligned_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr[1:0] != 2'b00) |=> ($stable(ctrl_q) && $stable(tb_q) && $stable(duty_q)));

   // R3
   tb_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && aligned && word_idx == IDX_W'(1) && wdata[FLD_W-1:TB_W] != '0)
      |=> (tb_q[0] == TB_W'(TB_MAX)));

endmodule

// File: rtl/pwmq_prescaler.sv
`timescale 1ns/1ps
module pwmq_prescaler #(
   parameter int DIV_A = 8,
   parameter int DIV_B = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  pwmq_pkg::step_sel_e sel,
   output logic                tick
);
   import pwmq_pkg::*;

   localparam int WA = (DIV_A > 1) ? $clog2(DIV_A) : 1;
   localparam int WB = (DIV_B > 1) ? $clog2(DIV_B) : 1;

   if (DIV_A < 2 || DIV_B < 2) begin : g_bad_div
      $error("each divider stage must divide by at least 2");
   end

   logic [WA-1:0] cnt_a;
   logic [WB-1:0] cnt_b;
   logic          wrap_a, wrap_b, adv_b;

   assign wrap_a = (cnt_a == WA'(DIV_A - 1));
   assign wrap_b = (cnt_b == WB'(DIV_B - 1));
   // Second stage counts input cycles alone, or stage-A wraps when chained.
   assign adv_b  = (sel == STEP_DIV_AB) ? wrap_a : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_a <= '0;
         cnt_b <= '0;
      end else begin
         cnt_a <= wrap_a ? '0 : cnt_a + 1'b1;
         if (adv_b) cnt_b <= wrap_b ? '0 : cnt_b + 1'b1;
      end
   end

   always_comb begin
      unique case (sel)
         STEP_EVERY:  tick = run;
         STEP_DIV_A:  tick = run && wrap_a;
         STEP_DIV_B:  tick = run && wrap_b;
         STEP_DIV_AB: tick = run && wrap_a && wrap_b;
         default:     tick = 1'b0;
      endcase
   end

   // R8
   restart_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt_a == '0 && cnt_b == '0));

   // R5
   div_a_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel == STEP_DIV_A) |=> (cnt_a == '0));

endmodule

// File: rtl/pwmq_channel.sv
`timescale 1ns/1ps
module pwmq_channel #(
   parameter int TB_W    = 8,
   parameter int DUTY_W  = 16,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [TB_W-1:0]   live_tb,
   input  logic [DUTY_W-1:0] live_duty,
   output logic              pwm
);
   if (TB_W >= DUTY_W) begin : g_bad_w
      $error("duty field must be wider than the timebase");
   end

   logic [TB_W-1:0]   tb_s;
   logic [DUTY_W-1:0] duty_s;
   logic [TB_W-1:0]   step_q;
   logic              halted, last_step, level;

   assign halted    = (tb_s == '0);
   assign last_step = (step_q == tb_s - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= '0;
         tb_s   <= '0;
         duty_s <= '0;
      end else if (!run || halted) begin
         step_q <= '0;
         tb_s   <= live_tb;
         duty_s <= live_duty;
      end else if (tick) begin
         if (last_step) begin
            step_q <= '0;
            tb_s   <= live_tb;
            duty_s <= live_duty;
         end else begin
            step_q <= step_q + 1'b1;
         end
      end
   end

   assign level = run && !halted && (DUTY_W'(step_q) < duty_s);

   if (OUT_REG) begin : g_out_ff
      always_ff @(posedge clk) begin
         if (!rst_n) pwm <= 1'b0;
         else        pwm <= level;
      end
   end else begin : g_out_comb
      assign pwm = level;
   end

   // R4
   step_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !halted) |-> (step_q < tb_s));

   // R7
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !halted && !(tick && last_step)) |=> ($stable(tb_s) && $stable(duty_s)));

   // R6
   full_duty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !halted && duty_s >= DUTY_W'(tb_s)) |-> level);

endmodule

// File: rtl/pwm_quad.sv
`timescale 1ns/1ps
module pwm_quad #(
   parameter int NUM_CH  = 4,
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int TB_W    = 8,
   parameter int DIV_A   = 8,
   parameter int DIV_B   = 64,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   import pwmq_pkg::*;

   localparam int DUTY_W = DATA_W / 2;

   logic [NUM_CH-1:0]              run;
   logic [NUM_CH-1:0][SEL_W-1:0]   sel;
   logic [NUM_CH-1:0][TB_W-1:0]    tb;
   logic [NUM_CH-1:0][DUTY_W-1:0]  duty;
   logic [NUM_CH-1:0]              tick;

   pwmq_regs #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .TB_W   (TB_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bus_we),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .rdata   (bus_rdata),
      .ch_run  (run),
      .ch_sel  (sel),
      .ch_tb   (tb),
      .ch_duty (duty)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      pwmq_prescaler #(
         .DIV_A (DIV_A),
         .DIV_B (DIV_B)
      ) u_pre (
         .clk   (clk),
         .rst_n (rst_n),
         .run   (run[n]),
         .sel   (step_sel_e'(sel[n])),
         .tick  (tick[n])
      );

      pwmq_channel #(
         .TB_W    (TB_W),
         .DUTY_W  (DUTY_W),
         .OUT_REG (OUT_REG)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .run       (run[n]),
         .tick      (tick[n]),
         .live_tb   (tb[n]),
         .live_duty (duty[n]),
         .pwm       (pwm_out[n])
      );
   end

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (pwm_out == '0 && bus_rdata == '0));

endmodule

// File: tb/pwm_quad_tb.sv
`timescale 1ns/1ps
module pwm_quad_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   always #2.5 clk = ~clk;

   pwm_quad u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   int chks = 0;
   int errs = 0;
   int gk   = 0;
   bit done = 1'b0;
   int org [4];
   int e_n [4];
   int e_tb[4];
   int e_du[4];
   bit e_en[4];

   function automatic logic [3:0] exp_vec();
      logic [3:0] v;
      v = '0;
      for (int c = 0; c < 4; c++) begin
         if (e_en[c] && e_tb[c] != 0) begin
            v[c] = (((gk - org[c]) / e_n[c]) % e_tb[c]) < e_du[c];
         end
      end
      return v;
   endfunction

   // Check the outputs of the current cycle, then move to the next one.
   task automatic step(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         logic [3:0] ev;
         ev = exp_vec();
         chks++;
         if (pwm_out !== ev) begin
            errs++;
            $display("FAIL %s cycle %0d pwm_out=%b expected=%b", tag, gk, pwm_out, ev);
         end
         @(negedge clk);
         gk++;
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
      bus_we    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      step(1, tag);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #1;
      chks++;
      if (bus_rdata !== exp) begin
         errs++;
         $display("FAIL %s read 0x%02h got=%08h expected=%08h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic set_ch(input int c, input int n, input int tb, input int du);
      e_en[c] = 1'b1;
      e_n[c]  = n;
      e_tb[c] = tb;
      e_du[c] = du;
      org[c]  = gk;
   endtask

   function automatic logic [31:0] cfg(input int tb, input int du);
      return {du[15:0], tb[15:0]};
   endfunction

   initial begin
      for (int c = 0; c < 4; c++) begin
         org[c] = 0; e_n[c] = 1; e_tb[c] = 0; e_du[c] = 0; e_en[c] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents and quiet outputs
      rd(5'h00, 32'h0, "R1");
      for (int c = 0; c < 4; c++) rd(5'(4 + 4*c), 32'h0, "R1");
      step(2, "R1");

      // R3: field layout and timebase saturation
      wr(5'h04, 32'h0123_01F0, "R3");
      rd(5'h04, 32'h0123_00FF, "R3");
      wr(5'h08, 32'h0006_0005, "R3");
      rd(5'h08, 32'h0006_0005, "R3");
      // R10: neighbouring word untouched by the second write
      rd(5'h04, 32'h0123_00FF, "R10");

      // R2: control word read back whole (no run bits set)
      wr(5'h00, 32'hDEAD_BEE0, "R2");
      rd(5'h00, 32'hDEAD_BEE0, "R2");
      wr(5'h00, 32'h0, "R2");

      // R11: misaligned and unmapped writes ignored
      wr(5'h02, 32'hFFFF_FFFF, "R11");
      wr(5'h14, 32'hFFFF_FFFF, "R11");
      wr(5'h1C, 32'hFFFF_FFFF, "R11");
      rd(5'h14, 32'h0, "R11");
      rd(5'h02, 32'h0, "R11");
      rd(5'h00, 32'h0, "R11");
      rd(5'h04, 32'h0123_00FF, "R11");
      rd(5'h08, 32'h0006_0005, "R11");
      rd(5'h0C, 32'h0, "R11");
      rd(5'h10, 32'h0, "R11");

      // R9: zero timebase keeps a running channel low
      wr(5'h04, 32'h0005_0000, "R9");
      wr(5'h00, 32'h1, "R9");
      set_ch(0, 1, 0, 5);
      step(20, "R9");
      wr(5'h00, 32'h0, "R9");
      e_en[0] = 1'b0;

      // R4 and R6: sweep timebase and duty at full step rate
      for (int tb = 1; tb <= 6; tb++) begin
         for (int du = 0; du <= tb + 1; du++) begin
            string tag;
            tag = (du == 0 || du >= tb) ? "R6" : "R4";
            wr(5'h04, cfg(tb, du), tag);
            wr(5'h00, 32'h1, tag);
            set_ch(0, 1, tb, du);
            step(2*tb + 1, tag);
            wr(5'h00, 32'h0, tag);
            e_en[0] = 1'b0;
         end
      end

      // R5: each step-rate code on channel 3 (select at bits 11:10)
      for (int code = 0; code < 4; code++) begin
         int n;
         n = 1 << (3*code);
         wr(5'h10, cfg(3, 1), "R5");
         wr(5'h00, (32'(code) << 10) | 32'h8, "R5");
         set_ch(3, n, 3, 1);
         step(6*n + 2, "R5");
         wr(5'h00, 32'h0, "R5");
         e_en[3] = 1'b0;
      end

      // R10: four channels with distinct settings together
      wr(5'h04, cfg(4, 1), "R10");
      wr(5'h08, cfg(2, 1), "R10");
      wr(5'h0C, cfg(3, 2), "R10");
      wr(5'h10, cfg(5, 5), "R10");
      wr(5'h00, 32'h0000_018F, "R10");
      set_ch(0, 1, 4, 1);
      set_ch(1, 64, 2, 1);
      set_ch(2, 8, 3, 2);
      set_ch(3, 1, 5, 5);
      step(300, "R10");

      // R7: write lands in the last cycle of a channel-0 period
      while (((gk - org[0]) % 4) != 3) step(1, "R10");
      wr(5'h04, cfg(7, 5), "R7");
      org[0] = gk;
      step(4, "R7");
      set_ch(0, 1, 7, 5);
      step(21, "R7");

      // R8: stop channel 2 mid-prescale, then restart
      while (((gk - org[2]) % 8) != 3) step(1, "R10");
      wr(5'h00, 32'h0000_018B, "R8");
      e_en[2] = 1'b0;
      step(5, "R8");
      wr(5'h00, 32'h0000_018F, "R8");
      set_ch(2, 8, 3, 2);
      step(60, "R8");

      wr(5'h00, 32'h0, "R8");
      for (int c = 0; c < 4; c++) e_en[c] = 1'b0;
      step(3, "R8");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chks++;
         errs++;
         $display("FAIL watchdog expired at cycle %0d", gk);
         $display("Result: errors=%0d of %0d checks", errs, chks);
         $finish;
      end
   end

endmodule